// File: doc/BRIEF.md
# Floating-Point Reciprocal Estimate Unit

This unit returns an approximation of 1/x, good to about seven bits, for one floating-point operand per cycle. Half, single and double precision are supported. A two-bit format code selects one of them, and the operand of a narrower format is taken from the low bits of a 64-bit input. The mantissa of the estimate comes from a 128-entry table of 7-bit values. The table is indexed by the seven leading fraction bits of the operand.

Special operands are handled as follows:
- Infinities and zeros map to each other.
- NaNs collapse to the canonical NaN of the selected format.
- Subnormal operands are normalized first. Tiny ones overflow, and the rounding mode then chooses between infinity and the largest finite magnitude.

Very large operands give subnormal estimates. These are built by shifting right, without raising underflow. A single register stage holds the result and the five exception flags.

Top module: `frecip_est`

## Requirements
- R1: `out_valid` rises in the cycle after an accepted `in_valid` and falls in the cycle after `in_valid` is low. While `out_valid` is low, every flag output is 0. After reset, `out_valid` and all flags are 0.
- R2: An infinity of either sign (exponent all ones, fraction zero) gives a zero of the same sign, with no flags.
- R3: A zero of either sign gives an infinity of the same sign and sets `flag_divzero` only.
- R4: A NaN (exponent all ones, fraction nonzero) gives the canonical NaN: 16'h7E00, 32'h7FC00000 or 64'h7FF8000000000000. If the top fraction bit is 0 (a signaling NaN), `flag_invalid` is set. A quiet NaN (top fraction bit 1) raises no flag.
- R5: For a normal operand with biased exponent e, the result has the following fields, and no flag is raised:
  - sign: the operand sign;
  - exponent: 2·bias − 1 − e, where bias = 2^(E−1) − 1;
  - fraction: the top seven bits are T[i], with i the top seven operand fraction bits and T[i] the nearest integer to 65536/(257+2i) − 128; the other fraction bits are zero.
- R6: A subnormal operand with k leading zero fraction bits, where k ≤ 1, is treated as exponent −k. Its fraction is shifted left by k+1 with the overflowing bit dropped, and the result is formed as in R5.
- R7: A subnormal operand with k ≥ 2 sets `flag_overflow` and `flag_inexact`. The result keeps the operand sign. Its magnitude is chosen by `rm` (0 = nearest-even, 1 = toward zero, 2 = down, 3 = up, 4 = nearest-away):
  - largest finite magnitude for `rm` 1, for `rm` 2 with a positive operand, and for `rm` 3 with a negative operand;
  - infinity otherwise.
- R8: When the R5 exponent comes to 0, the result exponent is 0 and the fraction is a 1 followed by T[i]. When it comes to −1, the exponent is 0 and the fraction is 01 followed by T[i]. Neither case raises underflow or inexact.
- R9: `fmt` selects half (0, 5/10 bits), single (1, 8/23 bits) or double (2, 11/52 bits). For the narrower formats, operand bits above the format width are ignored and the result bits above it are zero.
- R10: `flag_underflow` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| fmt | input | 2 | Format: 0 half, 1 single, 2 double |
| rm | input | 3 | Rounding-mode code |
| operand | input | 64 | Operand, right-aligned for narrow formats |
| out_valid | output | 1 | Result and flags valid |
| result | output | 64 | Estimate of 1/operand, right-aligned |
| flag_invalid | output | 1 | Signaling NaN operand |
| flag_divzero | output | 1 | Zero operand |
| flag_overflow | output | 1 | Tiny subnormal overflowed |
| flag_underflow | output | 1 | Underflow (always 0) |
| flag_inexact | output | 1 | Inexact (set with overflow) |

## Verification
The properties assume the following about the inputs:
- `in_valid` is low while reset is applied and carries known values afterwards;
- `fmt` only takes the codes 0 to 2;
- the zero-operand property watches double-format operands, so it relies on the sign and exponent fields lying where that format puts them.

The stimulus changes inputs only on falling edges and holds `in_valid` low through reset. It draws formats only from 0 to 2, and fills the operand bits above the narrow formats with random data, which the design must ignore.

// File: rtl/frecip_est.sv
module frecip_est #(
  parameter int XLEN = 64,
  parameter int TBITS = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      fmt,
  input  logic [2:0]      rm,
  input  logic [XLEN-1:0] operand,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            flag_invalid,
  output logic            flag_divzero,
  output logic            flag_overflow,
  output logic            flag_underflow,
  output logic            flag_inexact
);
  localparam int FW = 52;
  localparam int EW = 11;
  localparam int TN = 1 << TBITS;

  function automatic logic [TBITS-1:0] tab_val(input int i);
    int d;
    d = 257 + 2 * i;
    return TBITS'((131072 + d) / (2 * d) - 128);
  endfunction

  logic [TBITS-1:0] rtab [TN];
  for (genvar g = 0; g < TN; g++) begin : g_tab
    assign rtab[g] = tab_val(g);
  end

  logic              sgn;
  logic [EW-1:0]     ex, emax;
  logic [FW-1:0]     fr;
  logic signed [12:0] bias2m1;

  always_comb begin
    case (fmt)
      2'd0: begin
        sgn = operand[15]; ex = {6'b0, operand[14:10]};
        fr = {operand[9:0], 42'b0}; emax = 11'h01F; bias2m1 = 13'sd29;
      end
      2'd1: begin
        sgn = operand[31]; ex = {3'b0, operand[30:23]};
        fr = {operand[22:0], 29'b0}; emax = 11'h0FF; bias2m1 = 13'sd253;
      end
      default: begin
        sgn = operand[63]; ex = operand[62:52];
        fr = operand[51:0]; emax = 11'h7FF; bias2m1 = 13'sd2045;
      end
    endcase
  end

  wire fr_nz   = |fr;
  wire is_inf  = (ex == emax) && !fr_nz;
  wire is_nan  = (ex == emax) && fr_nz;
  wire is_snan = is_nan && !fr[FW-1];
  wire is_zero = (ex == '0) && !fr_nz;
  wire is_sub  = (ex == '0) && fr_nz;

  logic [5:0] lz;
  logic       hit;
  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (!hit) begin
        if (fr[i]) hit = 1'b1;
        else       lz  = lz + 6'd1;
      end
    end
  end

  wire ovf = is_sub && (lz >= 6'd2);
  wire [FW-1:0] nfr = is_sub ? (fr << (lz + 6'd1)) : fr;
  wire signed [12:0] e_norm = is_sub ? -$signed({7'b0, lz}) : $signed({2'b0, ex});
  wire signed [12:0] oexp = bias2m1 - e_norm;
  wire [TBITS-1:0] tval = rtab[nfr[FW-1 -: TBITS]];
  wire to_max = (rm == 3'd1) || (rm == 3'd2 && !sgn) || (rm == 3'd3 && sgn);

  logic [FW-1:0] mfr;
  logic [EW-1:0] mex;
  logic          msg;
  always_comb begin
    msg = sgn;
    if (is_nan) begin
      msg = 1'b0; mex = emax; mfr = {1'b1, {(FW-1){1'b0}}};
    end else if (is_inf) begin
      mex = '0; mfr = '0;
    end else if (is_zero) begin
      mex = emax; mfr = '0;
    end else if (ovf) begin
      mex = to_max ? emax - 11'd1 : emax;
      mfr = to_max ? '1 : '0;
    end else if (oexp == 13'sd0) begin
      mex = '0; mfr = {1'b1, tval, {(FW-TBITS-1){1'b0}}};
    end else if (oexp == -13'sd1) begin
      mex = '0; mfr = {2'b01, tval, {(FW-TBITS-2){1'b0}}};
    end else begin
      mex = oexp[EW-1:0]; mfr = {tval, {(FW-TBITS){1'b0}}};
    end
  end

  logic [XLEN-1:0] packed_res;
  always_comb begin
    case (fmt)
      2'd0:    packed_res = {48'b0, msg, mex[4:0], mfr[FW-1 -: 10]};
      2'd1:    packed_res = {32'b0, msg, mex[7:0], mfr[FW-1 -: 23]};
      default: packed_res = {msg, mex, mfr};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      result        <= '0;
      flag_invalid  <= 1'b0;
      flag_divzero  <= 1'b0;
      flag_overflow <= 1'b0;
      flag_inexact  <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      flag_invalid  <= in_valid && is_snan;
      flag_divzero  <= in_valid && is_zero;
      flag_overflow <= in_valid && ovf;
      flag_inexact  <= in_valid && ovf;
      if (in_valid) result <= packed_res;
    end
  end

  assign flag_underflow = 1'b0;
endmodule

// File: rtl/frecip_est_chk.sv
module frecip_est_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  fmt,
  input logic [63:0] operand,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        flag_invalid,
  input logic        flag_divzero,
  input logic        flag_overflow,
  input logic        flag_inexact
);
  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R1
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(flag_invalid || flag_divzero || flag_overflow || flag_inexact));
  // R7
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> flag_inexact);
  // R4
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_invalid, flag_divzero, flag_overflow}));
  // R9
  half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'd0) |=> (result[63:16] == 48'b0));
  // R9
  single_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'd1) |=> (result[63:32] == 32'b0));
  // R3
  dbl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'd2 && operand[62:0] == 63'b0) |=>
      (flag_divzero && result[62:0] == {11'h7FF, 52'b0} && result[63] == $past(operand[63])));
endmodule

bind frecip_est frecip_est_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .operand(operand),
  .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
  .flag_divzero(flag_divzero), .flag_overflow(flag_overflow), .flag_inexact(flag_inexact)
);

// File: tb/tb_frecip_est.sv
module tb_frecip_est;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [2:0]  rm = 3'd0;
  logic [63:0] operand = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        f_nv, f_dz, f_of, f_uf, f_nx;

  int n_tests = 0;
  int n_fail = 0;
  logic        exp_valid = 1'b0;
  logic [68:0] exp_val = '0;
  string       exp_tag = "R1";
  logic [63:0] lfsr = 64'h9E3779B97F4A7C15;

  frecip_est dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .rm(rm),
    .operand(operand), .out_valid(out_valid), .result(result),
    .flag_invalid(f_nv), .flag_divzero(f_dz), .flag_overflow(f_of),
    .flag_underflow(f_uf), .flag_inexact(f_nx)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int ew(input int f);
    return (f == 0) ? 5 : (f == 1) ? 8 : 11;
  endfunction
  function automatic int fw(input int f);
    return (f == 0) ? 10 : (f == 1) ? 23 : 52;
  endfunction

  // Returns {invalid, divzero, overflow, underflow, inexact, result}
  function automatic logic [68:0] model(input int f, input int r, input logic [63:0] x);
    int E, F, e, oe, idx, t;
    logic [63:0] em, fm, ex, fr, ofr, sb;
    logic s;
    E = ew(f); F = fw(f);
    em = (64'd1 << E) - 1;
    fm = (64'd1 << F) - 1;
    s  = x[E + F];
    sb = {63'b0, s} << (E + F);
    ex = (x >> F) & em;
    fr = x & fm;
    if (ex == em && fr == 0) return {5'b00000, sb};
    if (ex == 0 && fr == 0) return {5'b01000, sb | (em << F)};
    if (ex == em) begin
      if (fr[F-1] == 1'b0) return {5'b10000, (em << F) | (64'd1 << (F - 1))};
      return {5'b00000, (em << F) | (64'd1 << (F - 1))};
    end
    e = int'(ex);
    if (ex == 0) begin
      while (fr[F-1] == 1'b0) begin
        e = e - 1;
        fr = fr << 1;
      end
      fr = (fr << 1) & fm;
      if (e < -1) begin
        if (r == 1 || (r == 2 && !s) || (r == 3 && s))
          return {5'b00101, sb | ((em << F) - 1)};
        return {5'b00101, sb | (em << F)};
      end
    end
    idx = int'(fr >> (F - 7));
    t = $rtoi(128.0 * (2.0 / (1.0 + (2.0 * idx + 1.0) / 256.0) - 1.0) + 0.5);
    ofr = 64'(t) << (F - 7);
    oe = 2 * ((1 << (E - 1)) - 1) - 1 - e;
    if (oe == 0 || oe == -1) begin
      ofr = (ofr >> 1) | (64'd1 << (F - 1));
      if (oe == -1) ofr = ofr >> 1;
      oe = 0;
    end
    return {5'b00000, sb | (64'(oe) << F) | ofr};
  endfunction

  task automatic check_now();
    logic [68:0] got;
    got = {f_nv, f_dz, f_of, f_uf, f_nx, result};
    n_tests++;
    if (out_valid !== exp_valid) begin
      n_fail++;
      $display("FAIL %s: out_valid=%b expected %b", exp_tag, out_valid, exp_valid);
    end else if (exp_valid && got !== exp_val) begin
      n_fail++;
      $display("FAIL %s: flags/result=%b/%h expected %b/%h", exp_tag,
               got[68:64], got[63:0], exp_val[68:64], exp_val[63:0]);
    end else if (!exp_valid && got[68:64] !== 5'b0) begin
      n_fail++;
      $display("FAIL %s: idle flags=%b expected 00000", exp_tag, got[68:64]);
    end
  endtask

  task automatic step(input logic v, input int f, input int r, input logic [63:0] x,
                      input string tag);
    @(negedge clk);
    check_now();
    in_valid = v;
    fmt = 2'(f);
    rm = 3'(r);
    operand = x;
    exp_valid = v;
    exp_val = model(f, r, x);
    exp_tag = v ? tag : "R1";
  endtask

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] q;
    q = s ^ (s << 13);
    q = q ^ (q >> 7);
    q = q ^ (q << 17);
    return q;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_now();
    rst_n = 1'b1;
    for (int f = 0; f < 3; f++) begin
      int E, F, B;
      logic [63:0] em, fm, sb;
      E = ew(f); F = fw(f); B = (1 << (E - 1)) - 1;
      em = (64'd1 << E) - 1;
      fm = (64'd1 << F) - 1;
      sb = 64'd1 << (E + F);
      step(1, f, 0, 64'd0, "R3");
      step(1, f, 2, sb, "R3");
      step(1, f, 0, em << F, "R2");
      step(1, f, 3, sb | (em << F), "R2");
      step(1, f, 0, (em << F) | 64'd1, "R4");
      step(1, f, 0, sb | (em << F) | (fm >> 1), "R4");
      step(1, f, 1, (em << F) | (64'd1 << (F - 1)), "R4");
      step(1, f, 0, sb | (em << F) | fm, "R4");
      step(1, f, 0, fm, "R6");
      step(1, f, 0, sb | (64'd1 << (F - 1)) | 64'd5, "R6");
      step(1, f, 0, (64'd1 << (F - 2)) | 64'd3, "R6");
      step(1, f, 4, sb | (64'd1 << (F - 2)) | (64'd1 << (F - 4)), "R6");
      for (int r = 0; r < 5; r++) begin
        step(1, f, r, 64'd1, "R7");
        step(1, f, r, sb | 64'd1, "R7");
        step(1, f, r, sb | (64'd1 << (F - 3)), "R7");
      end
      step(1, f, 0, ((em - 1) << F) | fm, "R8");
      step(1, f, 0, sb | ((em - 1) << F), "R8");
      step(1, f, 0, ((em - 2) << F) | (64'd5 << (F - 7)), "R8");
      step(1, f, 0, ((em - 3) << F), "R5");
      step(1, f, 0, 64'd1 << F, "R5");
      for (int i = 0; i < 128; i++)
        step(1, f, i % 5, ((i % 2) ? sb : 64'd0) | (64'(B) << F) | (64'(i) << (F - 7)) | 64'(i % 3),
             "R5");
      step(0, f, 0, 64'd0, "R1");
      step(0, f, 0, 64'd0, "R1");
    end
    for (int k = 0; k < 600; k++) begin
      lfsr = nxt(lfsr);
      step(1, int'(lfsr[63:62]) % 3, int'(lfsr[5:3]) % 5, lfsr, "R9");
      if (k % 50 == 49) step(0, 0, 0, 64'd0, "R1");
    end
    step(0, 0, 0, 64'd0, "R1");
    step(0, 0, 0, 64'd0, "R10");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule